// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is a byte-wide SPI master. It has a transmit queue and a receive queue of 64 bytes each and is driven through a small word-addressed register port. Software fills the transmit queue, writes a total byte count and a transmit byte count, and then writes the control register with the start bit set. The engine clocks the whole burst on its own, using the programmed clock polarity, clock phase and bit order. It stores each received byte unless discard is selected, and when the last byte has been shifted it raises a completion flag that can drive an interrupt.

Bytes past the transmit count go out as 0x00, so a read-only tail needs no padding in the queue. If the transmit queue runs dry while transmit bytes are still owed, the serial clock stops at its idle level until software supplies the next byte. The serial bit rate comes from an external divider as a half-period tick. Chip-select generation lives outside this block.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, the control, interrupt-enable, status, count and queue-status registers all read zero, `irq` is low and `sclk` is low.
- R2: A write to offset 0x04 pushes bits 7:0 into the transmit queue, which holds 64 bytes. A write to a full queue is dropped. The transmit fill level, 0 to 64, reads at offset 0x28 bits 22:16.
- R3: A read of offset 0x00 returns the oldest received byte and removes it. The receive fill level, 0 to 64, reads at offset 0x28 bits 6:0. Bytes come out in arrival order.
- R4: A control write (offset 0x08) with bit 10 and bit 0 both set, made while idle, starts a burst. Bit 10 reads as 1 while the burst runs. If bit 0 is clear, the start is ignored.
- R5: A burst clocks exactly as many bytes as the total count (offset 0x20, low 24 bits), each as 8 full `sclk` periods. The first bytes, as many as the transmit count (offset 0x24, low 24 bits), are taken from the transmit queue in order.
- R6: Bytes after the transmit count is used up are sent as 0x00.
- R7: Control bit 3 sets the idle level of `sclk`. With control bit 2 clear, data is sampled on the leading edge of each clock period. With it set, data is sampled on the trailing edge.
- R8: With control bit 6 clear, the most significant bit goes first on the wire. With it set, the least significant bit goes first. Received bits are assembled in the same order.
- R9: While control bit 15 is set, received bytes are not stored in the receive queue.
- R10: Status bit 16 (offset 0x10) is set on the same clock edge where control bit 10 returns to 0 at the end of a burst. Writing 1 to status bit 16 clears it. Writing 0 there leaves it unchanged.
- R11: `irq` is high only while status bit 16 and interrupt-enable bit 16 (offset 0x0C) are both set.
- R12: A control write with bit 8 set empties the transmit queue, and one with bit 9 set empties the receive queue, before the next cycle. Both bits always read back as 0.
- R13: If the transmit queue is empty while transmit bytes are still owed, `sclk` stays at its idle level and the burst waits until a byte is pushed.
- R14: A total count of zero completes the burst with no `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x00) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |
| sclk_tick | input | 1 | Half-period tick from the external bit-rate divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is the mid-burst stall. In it, the engine owes transmit bytes, the queue is empty and the clock is parked. The bench reaches it by programming a transmit count of three, pushing only one byte, and starting. After the first byte it confirms that the start bit still reads 1 and that no further `sclk` edges appear over hundreds of cycles. It then pushes the two missing bytes and checks that the burst resumes and completes. A bench-side wire monitor decodes `mosi` on the sampling edge chosen by the mode, which checks bit order and phase independently of the loopback receive path.

// File: rtl/sbe_pkg.sv
// Shared constants and types for the SPI burst engine.
// Assumes a 32-bit register port addressed by byte offset.
package sbe_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 64;
    localparam int COUNT_W    = 24;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 6;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_IRQEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_TOTAL  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_XMIT   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_LEVELS = 6'h28;

    // control bit positions
    localparam int CB_ENABLE  = 0;
    localparam int CB_MASTER  = 1;
    localparam int CB_PHASE   = 2;
    localparam int CB_POL     = 3;
    localparam int CB_LSBF    = 6;
    localparam int CB_TXFLUSH = 8;
    localparam int CB_RXFLUSH = 9;
    localparam int CB_GO      = 10;
    localparam int CB_DROP    = 15;

    // status / irq-enable bit and level field positions
    localparam int SB_DONE    = 16;
    localparam int LV_RX_LSB  = 0;
    localparam int LV_TX_LSB  = 16;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_SHIFT
    } eng_state_t;

    typedef struct packed {
        logic pol;
        logic phase;
        logic lsb_first;
        logic drop_rx;
    } wire_mode_t;

endpackage

// File: rtl/sbe_fifo.sv
// Byte queue with a flush input and a fill count.
// Assumes DEPTH is a power of two. Pushes when full and pops when
// empty are dropped. Flush has priority over push and pop.
module sbe_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    // pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sbe_shift_engine.sv
// Serial byte engine: walks a burst of byte slots, fetching transmit
// bytes while owed and zero bytes after, and shifts each over 2*W
// half-period ticks. Assumes tick is a one-cycle pulse from an
// external divider. The mode may change only while idle.
module sbe_shift_engine
    import sbe_pkg::*;
#(
    parameter  int W     = 8,
    parameter  int CNT_W = 24,
    localparam int BW    = $clog2(W),
    localparam int PH_W  = $clog2(2 * W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total_len,
    input  logic [CNT_W-1:0] xmit_len,
    input  wire_mode_t       mode,
    input  logic             tick,
    input  logic             miso,
    input  logic             tx_avail,
    input  logic [W-1:0]     tx_byte,
    output logic             tx_take,
    output logic             rx_put,
    output logic [W-1:0]     rx_byte,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * W - 1);
    localparam logic [BW-1:0]   K_LAST  = BW'(W - 1);

    eng_state_t       state;
    logic [CNT_W-1:0] total_left;
    logic [CNT_W-1:0] xmit_left;
    logic [W-1:0]     cur_tx;
    logic [W-1:0]     rx_acc;
    logic [W-1:0]     rx_merge;
    logic [W-1:0]     load_val;
    logic [PH_W-1:0]  phase;
    logic [BW-1:0]    k;
    logic             sclk_act;
    logic             mosi_q;
    logic             leading;
    logic             sample_now;
    logic             byte_end;
    logic             owe_tx;
    logic             load_byte;

    // wire position of logical bit k under the selected order
    function automatic logic [BW-1:0] bpos(input logic [BW-1:0] idx, input logic lsb);
        return lsb ? idx : (K_LAST - idx);
    endfunction

    assign k          = phase[PH_W-1:1];
    assign leading    = !phase[0];
    assign owe_tx     = (xmit_left != '0);
    assign sample_now = (state == ENG_SHIFT) && tick && (leading ^ mode.phase);
    assign byte_end   = (state == ENG_SHIFT) && tick && (phase == PH_LAST);
    assign done       = (state == ENG_FETCH) && (total_left == '0);
    assign load_byte  = (state == ENG_FETCH) && (total_left != '0) && (!owe_tx || tx_avail);
    assign tx_take    = load_byte && owe_tx;
    assign load_val   = owe_tx ? tx_byte : '0;
    assign rx_put     = byte_end && !mode.drop_rx;
    assign rx_byte    = rx_merge;
    assign sclk       = mode.pol ^ sclk_act;
    assign mosi       = mosi_q;
    assign busy       = (state != ENG_IDLE);

    // merge the bit being sampled this cycle into the receive byte
    always_comb begin
        rx_merge = rx_acc;
        if (sample_now) begin
            rx_merge[bpos(k, mode.lsb_first)] = miso;
        end
    end

    // burst sequencing, byte loading and per-tick shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            total_left <= '0;
            xmit_left  <= '0;
            cur_tx     <= '0;
            rx_acc     <= '0;
            phase      <= '0;
            sclk_act   <= 1'b0;
            mosi_q     <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        total_left <= total_len;
                        xmit_left  <= xmit_len;
                        state      <= ENG_FETCH;
                    end
                end
                ENG_FETCH: begin
                    if (done) begin
                        state <= ENG_IDLE;
                    end else if (load_byte) begin
                        cur_tx <= load_val;
                        rx_acc <= '0;
                        phase  <= '0;
                        if (!mode.phase) mosi_q <= load_val[bpos('0, mode.lsb_first)];
                        if (owe_tx) xmit_left <= xmit_left - 1'b1;
                        state  <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        sclk_act <= !sclk_act;
                        phase    <= phase + 1'b1;
                        rx_acc   <= rx_merge;
                        if (leading && mode.phase) begin
                            mosi_q <= cur_tx[bpos(k, mode.lsb_first)];
                        end
                        if (!leading && !mode.phase && (k != K_LAST)) begin
                            mosi_q <= cur_tx[bpos(k + 1'b1, mode.lsb_first)];
                        end
                        if (phase == PH_LAST) begin
                            total_left <= total_left - 1'b1;
                            state      <= ENG_FETCH;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_burst_engine.sv
// Top of the SPI burst engine: register file, two byte queues and the
// serial engine. Assumes one register access per cycle; read data is
// combinational and a read of the receive data offset pops the queue.
module spi_burst_engine
    import sbe_pkg::*;
#(
    parameter  int DEPTH = FIFO_DEPTH,
    parameter  int CNT_W = COUNT_W,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sclk_tick,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);

    logic             cfg_enable;
    logic             cfg_master;
    wire_mode_t       cfg_mode;
    logic             irq_en;
    logic             done_flag;
    logic [CNT_W-1:0] total_cnt;
    logic [CNT_W-1:0] xmit_cnt;

    logic             ctrl_wr;
    logic             start;
    logic             tx_flush;
    logic             rx_flush;
    logic             tx_push;
    logic             rx_pop;

    logic [DATA_W-1:0] tx_head;
    logic [DATA_W-1:0] rx_head;
    logic [DATA_W-1:0] eng_rx_byte;
    logic [CW-1:0]     tx_level;
    logic [CW-1:0]     rx_level;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;
    logic              eng_take;
    logic              eng_put;
    logic              eng_busy;
    logic              eng_done;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata, tx_full, rx_full};
    assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
    assign start    = ctrl_wr && reg_wdata[CB_GO] && reg_wdata[CB_ENABLE] && !eng_busy;
    assign tx_flush = ctrl_wr && reg_wdata[CB_TXFLUSH];
    assign rx_flush = ctrl_wr && reg_wdata[CB_RXFLUSH];
    assign tx_push  = reg_wr && (reg_addr == OFS_TXDATA);
    assign rx_pop   = reg_rd && (reg_addr == OFS_RXDATA);
    assign irq      = done_flag && irq_en;

    // configuration and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_enable <= 1'b0;
            cfg_master <= 1'b0;
            cfg_mode   <= '0;
            irq_en     <= 1'b0;
            total_cnt  <= '0;
            xmit_cnt   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL: begin
                    cfg_enable        <= reg_wdata[CB_ENABLE];
                    cfg_master        <= reg_wdata[CB_MASTER];
                    cfg_mode.phase    <= reg_wdata[CB_PHASE];
                    cfg_mode.pol      <= reg_wdata[CB_POL];
                    cfg_mode.lsb_first <= reg_wdata[CB_LSBF];
                    cfg_mode.drop_rx  <= reg_wdata[CB_DROP];
                end
                OFS_IRQEN: irq_en    <= reg_wdata[SB_DONE];
                OFS_TOTAL: total_cnt <= reg_wdata[CNT_W-1:0];
                OFS_XMIT:  xmit_cnt  <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // completion flag: set by the engine, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (eng_done) begin
            done_flag <= 1'b1;
        end else if (reg_wr && (reg_addr == OFS_STATUS) && reg_wdata[SB_DONE]) begin
            done_flag <= 1'b0;
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_RXDATA: reg_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
            OFS_CTRL: begin
                reg_rdata[CB_ENABLE] = cfg_enable;
                reg_rdata[CB_MASTER] = cfg_master;
                reg_rdata[CB_PHASE]  = cfg_mode.phase;
                reg_rdata[CB_POL]    = cfg_mode.pol;
                reg_rdata[CB_LSBF]   = cfg_mode.lsb_first;
                reg_rdata[CB_GO]     = eng_busy;
                reg_rdata[CB_DROP]   = cfg_mode.drop_rx;
            end
            OFS_IRQEN:  reg_rdata[SB_DONE] = irq_en;
            OFS_STATUS: reg_rdata[SB_DONE] = done_flag;
            OFS_TOTAL:  reg_rdata[CNT_W-1:0] = total_cnt;
            OFS_XMIT:   reg_rdata[CNT_W-1:0] = xmit_cnt;
            OFS_LEVELS: begin
                reg_rdata[LV_RX_LSB +: CW] = rx_level;
                reg_rdata[LV_TX_LSB +: CW] = tx_level;
            end
            default: ;
        endcase
    end

    sbe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .din   (reg_wdata[DATA_W-1:0]),
        .pop   (eng_take),
        .dout  (tx_head),
        .count (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sbe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (eng_put),
        .din   (eng_rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sbe_shift_engine #(.W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .total_len (total_cnt),
        .xmit_len  (xmit_cnt),
        .mode      (cfg_mode),
        .tick      (sclk_tick),
        .miso      (miso),
        .tx_avail  (!tx_empty),
        .tx_byte   (tx_head),
        .tx_take   (eng_take),
        .rx_put    (eng_put),
        .rx_byte   (eng_rx_byte),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (eng_busy),
        .done      (eng_done)
    );

endmodule

// File: rtl/sbe_checker.sv
// Property checker for the SPI burst engine, attached by bind.
// Assumes the signal names of spi_burst_engine.
module sbe_checker #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done_flag,
    input logic          irq,
    input logic          irq_en,
    input logic          sclk,
    input logic          pol,
    input logic          drop_rx,
    input logic          ctrl_wr,
    input logic          tx_flush_bit,
    input logic          rx_flush_bit,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level
);

    p_done_at_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_sclk_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == pol));

    p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= CW'(DEPTH));

    p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CW'(DEPTH));

    p_tx_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && tx_flush_bit) |=> (tx_level == '0));

    p_rx_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && rx_flush_bit) |=> (rx_level == '0));

    p_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drop_rx) |=> (rx_level <= $past(rx_level)));

endmodule

bind spi_burst_engine sbe_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (eng_busy),
    .done_flag    (done_flag),
    .irq          (irq),
    .irq_en       (irq_en),
    .sclk         (sclk),
    .pol          (cfg_mode.pol),
    .drop_rx      (cfg_mode.drop_rx),
    .ctrl_wr      (ctrl_wr),
    .tx_flush_bit (reg_wdata[sbe_pkg::CB_TXFLUSH]),
    .rx_flush_bit (reg_wdata[sbe_pkg::CB_RXFLUSH]),
    .tx_level     (tx_level),
    .rx_level     (rx_level)
);

// File: tb/spi_burst_engine_test.sv
`timescale 1ns/1ps
module spi_burst_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk_tick = 1'b0;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit finished = 1'b0;

    // wire monitor state
    bit       mon_en = 1'b0;
    bit       cur_pol = 1'b0;
    bit       cur_pha = 1'b0;
    logic     sclk_prev = 1'b0;
    int       edges = 0;
    int       nbits = 0;
    int       nbytes = 0;
    logic [7:0] wire_sh = '0;
    logic [7:0] wire_bytes [64];

    localparam logic [31:0] EN = 32'h1, MST = 32'h2, PHA = 32'h4, POL = 32'h8;
    localparam logic [31:0] LSBF = 32'h40, TXF = 32'h100, RXF = 32'h200, GO = 32'h400, DROP = 32'h8000;
    localparam logic [31:0] DONE = 32'h1_0000;

    typedef struct packed {
        logic       pol;
        logic       pha;
        logic       lsb;
        logic       drop;
        logic [7:0] total;
        logic [7:0] xmit;
        logic [3:0] div;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd4,  4'd1, 8'h35},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd5,  8'd3,  4'd2, 8'hA1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  8'd3,  4'd1, 8'h5C},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd6,  8'd2,  4'd3, 8'h0F},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'd4,  4'd1, 8'h77},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd64, 8'd64, 4'd1, 8'h13}
    };

    spi_burst_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk_tick (sclk_tick),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .irq       (irq)
    );

    assign miso = mosi;

    always #2.5 clk = ~clk;

    // half-period tick source
    always @(posedge clk) begin
        if (tick_cnt >= tick_div - 1) begin
            tick_cnt  <= 0;
            sclk_tick <= 1'b1;
        end else begin
            tick_cnt  <= tick_cnt + 1;
            sclk_tick <= 1'b0;
        end
    end

    // wire monitor: decodes mosi on the sampling edge of the mode
    always @(negedge clk) begin
        if (mon_en && (sclk !== sclk_prev)) begin
            edges = edges + 1;
            if ((sclk_prev == cur_pol) ^ cur_pha) begin
                wire_sh = {wire_sh[6:0], mosi};
                nbits = nbits + 1;
                if (nbits % 8 == 0 && nbytes < 64) begin
                    wire_bytes[nbytes] = wire_sh;
                    nbytes = nbytes + 1;
                end
            end
        end
        sclk_prev = sclk;
    end

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(37 * i);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic mon_clear();
        edges = 0; nbits = 0; nbytes = 0; wire_sh = '0;
    endtask

    task automatic wait_irq(input int limit);
        for (int c = 0; c < limit && !irq; c++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] d;
        logic [31:0] mode;
        logic [7:0]  exp_b;
        mode = EN | MST | (v.pol ? POL : 0) | (v.pha ? PHA : 0) |
               (v.lsb ? LSBF : 0) | (v.drop ? DROP : 0);
        tick_div = int'(v.div);
        mon_en = 1'b0;
        wr(6'h08, mode | TXF | RXF);
        cur_pol = v.pol; cur_pha = v.pha;
        for (int i = 0; i < int'(v.xmit); i++) wr(6'h04, {24'h0, pat(v.seed, i)});
        wr(6'h20, {24'h0, v.total});
        wr(6'h24, {24'h0, v.xmit});
        wr(6'h0C, DONE);
        wr(6'h10, DONE);
        repeat (2) @(negedge clk);
        mon_clear();
        mon_en = 1'b1;
        wr(6'h08, mode | GO);
        wait_irq(8000);
        repeat (2) @(negedge clk);
        check(irq === 1'b1, $sformatf("R10 vec%0d irq after burst", idx), 32'(irq), 1);
        rd(6'h08, d);
        check(d[10] == 1'b0, $sformatf("R4 vec%0d go bit cleared", idx), 32'(d[10]), 0);
        check(edges == 16 * int'(v.total), $sformatf("R5 vec%0d sclk edges", idx), edges, 16 * int'(v.total));
        check(nbytes == int'(v.total), $sformatf("R5 vec%0d bytes on wire", idx), nbytes, int'(v.total));
        for (int i = 0; i < int'(v.total) && i < nbytes; i++) begin
            exp_b = (i < int'(v.xmit)) ? pat(v.seed, i) : 8'h00;
            // R6 zero tail, R7 sampling edge, R8 bit order
            check(wire_bytes[i] == (v.lsb ? rev8(exp_b) : exp_b),
                  $sformatf("R6/R7/R8 vec%0d wire byte %0d", idx, i), wire_bytes[i], v.lsb ? rev8(exp_b) : exp_b);
        end
        rd(6'h28, d);
        check(d[6:0] == (v.drop ? 7'd0 : 7'(v.total)), $sformatf("R9 vec%0d rx level", idx),
              d[6:0], v.drop ? 0 : v.total);
        check(d[22:16] == 7'd0, $sformatf("R2 vec%0d tx drained", idx), d[22:16], 0);
        if (!v.drop) begin
            for (int i = 0; i < int'(v.total); i++) begin
                exp_b = (i < int'(v.xmit)) ? pat(v.seed, i) : 8'h00;
                rd(6'h00, d);
                check(d[7:0] == exp_b, $sformatf("R3 vec%0d rx byte %0d", idx, i), d[7:0], exp_b);
            end
        end
        wr(6'h10, DONE);
        @(negedge clk);
        check(irq === 1'b0, $sformatf("R10 vec%0d w1c clears", idx), 32'(irq), 0);
        mon_en = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h08, d); check(d == 0, "R1 ctrl reset", d, 0);
        rd(6'h10, d); check(d == 0, "R1 status reset", d, 0);
        rd(6'h0C, d); check(d == 0, "R1 irq enable reset", d, 0);
        rd(6'h20, d); check(d == 0, "R1 total count reset", d, 0);
        rd(6'h28, d); check(d == 0, "R1 levels reset", d, 0);
        check(irq === 1'b0 && sclk === 1'b0, "R1 irq/sclk low", {30'h0, irq, sclk}, 0);

        // table-driven bursts
        for (int v = 0; v < 6; v++) run_vec(VECS[v], v);
        tick_div = 1;

        // R2 queue overflow drops writes
        wr(6'h08, EN | TXF | RXF);
        for (int i = 0; i < 70; i++) wr(6'h04, 32'(i));
        rd(6'h28, d); check(d[22:16] == 7'd64, "R2 tx level capped at 64", d[22:16], 64);
        // R12 tx flush, bit reads zero
        wr(6'h08, EN | TXF);
        rd(6'h28, d); check(d[22:16] == 7'd0, "R12 tx flush empties", d[22:16], 0);
        rd(6'h08, d); check(d[8] == 1'b0 && d[9] == 1'b0, "R12 flush bits read zero", d[9:8], 0);

        // R12 rx flush after a stored burst
        wr(6'h04, 32'h5A); wr(6'h04, 32'hC3);
        wr(6'h20, 2); wr(6'h24, 2);
        wr(6'h0C, DONE);
        wr(6'h08, EN | GO);
        wait_irq(2000);
        rd(6'h28, d); check(d[6:0] == 7'd2, "R3 rx level after burst", d[6:0], 2);
        wr(6'h08, EN | RXF);
        rd(6'h28, d); check(d[6:0] == 7'd0, "R12 rx flush empties", d[6:0], 0);
        wr(6'h10, DONE);

        // R4 start ignored when not enabled
        wr(6'h04, 32'h11); wr(6'h04, 32'h22);
        wr(6'h08, GO);
        rd(6'h08, d); check(d[10] == 1'b0, "R4 no start without enable", d[10], 0);
        repeat (50) @(negedge clk);
        rd(6'h10, d); check(d[16] == 1'b0, "R4 no completion without enable", d[16], 0);
        rd(6'h28, d); check(d[22:16] == 7'd2, "R4 tx queue untouched", d[22:16], 2);

        // R13 stall when queue runs dry
        wr(6'h08, EN | TXF | RXF);
        cur_pol = 1'b0; cur_pha = 1'b0;
        wr(6'h04, 32'h96);
        wr(6'h20, 3); wr(6'h24, 3);
        mon_clear(); mon_en = 1'b1;
        wr(6'h08, EN | GO);
        repeat (300) @(negedge clk);
        rd(6'h08, d); check(d[10] == 1'b1, "R4 go bit set while stalled", d[10], 1);
        check(edges == 16, "R13 only first byte clocked", edges, 16);
        check(sclk === 1'b0, "R13 sclk parked idle", 32'(sclk), 0);
        check(irq === 1'b0, "R13 no completion while stalled", 32'(irq), 0);
        wr(6'h04, 32'h3C); wr(6'h04, 32'hE1);
        wait_irq(2000);
        check(edges == 48, "R13 burst resumes", edges, 48);
        check(nbytes == 3 && wire_bytes[2] == 8'hE1, "R13 last byte after resume", wire_bytes[2], 8'hE1);
        mon_en = 1'b0;
        wr(6'h10, DONE);

        // R14 zero-length burst
        wr(6'h20, 0); wr(6'h24, 0);
        mon_clear(); mon_en = 1'b1;
        wr(6'h08, EN | GO);
        repeat (5) @(negedge clk);
        rd(6'h10, d); check(d[16] == 1'b1, "R14 zero burst completes", d[16], 1);
        check(edges == 0, "R14 zero burst no edges", edges, 0);
        mon_en = 1'b0;

        // R10 writing zero keeps flag; R11 masking
        wr(6'h10, 32'h0);
        rd(6'h10, d); check(d[16] == 1'b1, "R10 write zero keeps flag", d[16], 1);
        wr(6'h0C, 32'h0);
        @(negedge clk);
        check(irq === 1'b0, "R11 irq masked", 32'(irq), 0);
        wr(6'h0C, DONE);
        @(negedge clk);
        check(irq === 1'b1, "R11 irq unmasked", 32'(irq), 1);
        wr(6'h10, DONE);
        rd(6'h10, d); check(d[16] == 1'b0, "R10 write one clears", d[16], 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule